// File: doc/BRIEF.md
# Wall-Following Robot Steering Controller

This block is a Moore state machine that steers a small maze-walking robot so that a wall stays on its right-hand side. Two contact sensors, one on each side, feed it. Each sensor reads 1 while it touches a wall. Every clock the block issues three actuator commands: step forward, veer slightly left, and veer slightly right. The commands depend only on the registered state. The sensor inputs only choose the next state.

A parameter selects the build. The full build has five behaviours in a 3-bit state register. The compact build merges the two equivalent right-veering behaviours into one state held in 2 bits. Both builds produce the same command stream for any sensor stream. A synchronous, active-high reset starts the robot in the searching behaviour. In the full build, any state code that has no meaning returns to the searching behaviour on the next clock.

Top module: `wall_follower`

## Requirements
- R1: While `rst` is 1 at a rising edge, the state after that edge is the searching state. Its commands are `stepFwd`=1, `veerLeft`=0, `veerRight`=0.
- R2: Each state has a fixed command pattern, written {stepFwd,veerLeft,veerRight}. Searching is 100. Wall-ahead is 010. Hugging is 110. Both the gap-seen state and the wall-lost state are 101. `veerLeft` and `veerRight` are never 1 together.
- R3: From searching, the machine moves to wall-ahead if either sensor is 1. If both sensors are 0, it stays in searching.
- R4: From wall-ahead, the machine stays in wall-ahead while `senseLeft` is 1. If only `senseRight` is 1, it moves to hugging. If both sensors are 0, it moves to wall-lost.
- R5: From hugging, `senseLeft`=1 moves the machine to wall-ahead, whatever `senseRight` is. Otherwise `senseRight`=1 keeps it in hugging, and `senseRight`=0 moves it to wall-lost.
- R6: From wall-lost, `senseRight`=1 moves the machine to hugging and `senseRight`=0 moves it to gap-seen. Gap-seen behaves the same way: `senseRight`=1 moves it to hugging and `senseRight`=0 keeps it in gap-seen. In both states `senseLeft` is ignored.
- R7: Given the same reset and sensor sequence, the build with `MERGED`=1 produces the same three commands as the build with `MERGED`=0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, selects the searching state |
| senseLeft | input | 1 | Left contact sensor, 1 while touching a wall |
| senseRight | input | 1 | Right contact sensor, 1 while touching a wall |
| stepFwd | output | 1 | Command to step forward |
| veerLeft | output | 1 | Command to turn slightly left |
| veerRight | output | 1 | Command to turn slightly right |

## Verification
Wall-lost and gap-seen give the same commands, so the ports alone cannot show which of the two the machine is in. The bench reaches gap-seen by entering wall-ahead, releasing both sensors, and then holding `senseRight` at 0 for a further cycle. From there it applies every sensor pair in turn. The equivalence of the two builds is stressed with long random sensor streams run through both builds side by side. The unused 3-bit codes cannot be reached from the ports at all, and the bench does not try to reach them.

// File: rtl/wf_pkg.sv
package wf_pkg;
  // Actuator command strobes handed from control to datapath.
  typedef struct packed {
    logic fwd;
    logic left;
    logic right;
  } act_t;

  // Full build, 3-bit codes
  localparam logic [2:0] F_SEARCH = 3'b000;
  localparam logic [2:0] F_AHEAD  = 3'b001;
  localparam logic [2:0] F_HUG    = 3'b010;
  localparam logic [2:0] F_LOST   = 3'b011;
  localparam logic [2:0] F_GAP    = 3'b100;

  // Compact build, 2-bit codes
  localparam logic [1:0] C_SEARCH = 2'b00;
  localparam logic [1:0] C_AHEAD  = 2'b01;
  localparam logic [1:0] C_HUG    = 2'b10;
  localparam logic [1:0] C_VEER   = 2'b11;

  localparam act_t ACT_SEARCH = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
  localparam act_t ACT_AHEAD  = '{fwd: 1'b0, left: 1'b1, right: 1'b0};
  localparam act_t ACT_HUG    = '{fwd: 1'b1, left: 1'b1, right: 1'b0};
  localparam act_t ACT_VEER   = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
  localparam act_t ACT_IDLE   = '{fwd: 1'b0, left: 1'b0, right: 1'b0};
endpackage

// File: rtl/wf_state.sv
module wf_state #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] stateD,
  output logic [SW-1:0] stateQ
);
  // Code zero is the searching state in both builds.
  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end
endmodule

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
#(
  parameter bit MERGED = 1'b0,
  parameter int SW = MERGED ? 2 : 3
) (
  input  logic [SW-1:0] stateQ,
  input  logic          senseL,
  input  logic          senseR,
  output logic [SW-1:0] stateD,
  output act_t          act
);
  generate
    if (MERGED) begin : g_compact
      always_comb begin
        stateD = C_SEARCH;
        act    = ACT_IDLE;
        case (stateQ)
          C_SEARCH: begin
            act    = ACT_SEARCH;
            stateD = (senseL || senseR) ? C_AHEAD : C_SEARCH;
          end
          C_AHEAD: begin
            act = ACT_AHEAD;
            if (senseL)      stateD = C_AHEAD;
            else if (senseR) stateD = C_HUG;
            else             stateD = C_VEER;
          end
          C_HUG: begin
            act = ACT_HUG;
            if (senseL)      stateD = C_AHEAD;
            else if (senseR) stateD = C_HUG;
            else             stateD = C_VEER;
          end
          default: begin
            act    = ACT_VEER;
            stateD = senseR ? C_HUG : C_VEER;
          end
        endcase
      end
    end else begin : g_full
      always_comb begin
        stateD = F_SEARCH;
        act    = ACT_IDLE;
        case (stateQ)
          F_SEARCH: begin
            act    = ACT_SEARCH;
            stateD = (senseL || senseR) ? F_AHEAD : F_SEARCH;
          end
          F_AHEAD: begin
            act = ACT_AHEAD;
            if (senseL)      stateD = F_AHEAD;
            else if (senseR) stateD = F_HUG;
            else             stateD = F_LOST;
          end
          F_HUG: begin
            act = ACT_HUG;
            if (senseL)      stateD = F_AHEAD;
            else if (senseR) stateD = F_HUG;
            else             stateD = F_LOST;
          end
          F_LOST: begin
            act    = ACT_VEER;
            stateD = senseR ? F_HUG : F_GAP;
          end
          F_GAP: begin
            act    = ACT_VEER;
            stateD = senseR ? F_HUG : F_GAP;
          end
          default: begin
            act    = ACT_IDLE;
            stateD = F_SEARCH;
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/wall_follower.sv
module wall_follower
  import wf_pkg::*;
#(
  parameter bit MERGED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic senseLeft,
  input  logic senseRight,
  output logic stepFwd,
  output logic veerLeft,
  output logic veerRight
);
  localparam int SW = MERGED ? 2 : 3;

  logic [SW-1:0] stateQ;
  logic [SW-1:0] stateD;
  act_t          act;

  wf_ctrl #(.MERGED(MERGED), .SW(SW)) u_ctrl (
    .stateQ(stateQ),
    .senseL(senseLeft),
    .senseR(senseRight),
    .stateD(stateD),
    .act(act)
  );

  wf_state #(.SW(SW)) u_state (
    .clk(clk),
    .rst(rst),
    .stateD(stateD),
    .stateQ(stateQ)
  );

  assign stepFwd   = act.fwd;
  assign veerLeft  = act.left;
  assign veerRight = act.right;
endmodule

// File: rtl/wf_checker.sv
module wf_checker (
  input logic clk,
  input logic rst,
  input logic senseLeft,
  input logic senseRight,
  input logic stepFwd,
  input logic veerLeft,
  input logic veerRight
);
  logic isSearch, isAhead, isHug, isVeer;
  assign isSearch = stepFwd && !veerLeft && !veerRight;
  assign isAhead  = !stepFwd && veerLeft && !veerRight;
  assign isHug    = stepFwd && veerLeft && !veerRight;
  assign isVeer   = stepFwd && !veerLeft && veerRight;

  p_reset_search_r1: assert property (@(posedge clk) rst |=> isSearch);

  p_no_dual_turn_r2: assert property (@(posedge clk) disable iff (rst)
    !(veerLeft && veerRight));

  p_legal_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    isSearch || isAhead || isHug || isVeer);

  p_search_leave_r3: assert property (@(posedge clk) disable iff (rst)
    (isSearch && (senseLeft || senseRight)) |=> isAhead);

  p_search_stay_r3: assert property (@(posedge clk) disable iff (rst)
    (isSearch && !senseLeft && !senseRight) |=> isSearch);

  p_ahead_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (isAhead && senseLeft) |=> isAhead);

  p_ahead_hug_r4: assert property (@(posedge clk) disable iff (rst)
    (isAhead && !senseLeft && senseRight) |=> isHug);

  p_ahead_lost_r4: assert property (@(posedge clk) disable iff (rst)
    (isAhead && !senseLeft && !senseRight) |=> isVeer);

  p_hug_left_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (isHug && senseLeft) |=> isAhead);

  p_hug_stay_r5: assert property (@(posedge clk) disable iff (rst)
    (isHug && !senseLeft && senseRight) |=> isHug);

  p_hug_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (isHug && !senseLeft && !senseRight) |=> isVeer);

  p_veer_regain_r6: assert property (@(posedge clk) disable iff (rst)
    (isVeer && senseRight) |=> isHug);

  p_veer_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (isVeer && !senseRight) |=> isVeer);
endmodule

bind wall_follower wf_checker u_chk (
  .clk(clk),
  .rst(rst),
  .senseLeft(senseLeft),
  .senseRight(senseRight),
  .stepFwd(stepFwd),
  .veerLeft(veerLeft),
  .veerRight(veerRight)
);

// File: tb/tb_wall_follower.sv
module tb_wall_follower;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 4000;
  localparam int WATCHDOG = 100000;

  typedef enum int {M_SEARCH, M_AHEAD, M_HUG, M_LOST, M_GAP} mstate_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sL = 1'b0;
  logic sR = 1'b0;
  logic fA, lA, rA;
  logic fB, lB, rB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  mstate_t model = M_SEARCH;

  always #(CLK_PERIOD/2) clk = ~clk;

  wall_follower #(.MERGED(1'b0)) dut (
    .clk(clk), .rst(rst), .senseLeft(sL), .senseRight(sR),
    .stepFwd(fA), .veerLeft(lA), .veerRight(rA)
  );

  wall_follower #(.MERGED(1'b1)) dutMin (
    .clk(clk), .rst(rst), .senseLeft(sL), .senseRight(sR),
    .stepFwd(fB), .veerLeft(lB), .veerRight(rB)
  );

  function automatic logic [2:0] expAct(mstate_t s);
    case (s)
      M_SEARCH: return 3'b100;
      M_AHEAD:  return 3'b010;
      M_HUG:    return 3'b110;
      default:  return 3'b101;
    endcase
  endfunction

  function automatic mstate_t nextOf(mstate_t s, logic l, logic r);
    case (s)
      M_SEARCH: return (l || r) ? M_AHEAD : M_SEARCH;
      M_AHEAD:  return l ? M_AHEAD : (r ? M_HUG : M_LOST);
      M_HUG:    return l ? M_AHEAD : (r ? M_HUG : M_LOST);
      default:  return r ? M_HUG : M_GAP;
    endcase
  endfunction

  function automatic string tagOf(mstate_t s);
    case (s)
      M_SEARCH: return "R3";
      M_AHEAD:  return "R4";
      M_HUG:    return "R5";
      default:  return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b model=%0d t=%0t", tag, got, exp, model, $time);
    end
  endtask

  // Inputs change at the falling edge; outputs are read at the next falling edge.
  task automatic step(logic l, logic r);
    string tag;
    sL = l;
    sR = r;
    tag = tagOf(model);
    @(posedge clk);
    @(negedge clk);
    model = nextOf(model, l, r);
    check(tag, {fA, lA, rA}, expAct(model));
    check("R7", {fB, lB, rB}, {fA, lA, rA});
  endtask

  task automatic doReset();
    rst = 1'b1;
    sL = 1'b1;
    sR = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model = M_SEARCH;
    check("R1", {fA, lA, rA}, 3'b100);
    check("R1", {fB, lB, rB}, 3'b100);
    rst = 1'b0;
  endtask

  task automatic gotoState(mstate_t s);
    doReset();
    case (s)
      M_AHEAD: step(1'b1, 1'b0);
      M_HUG:   begin step(1'b1, 1'b0); step(1'b0, 1'b1); end
      M_LOST:  begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
      M_GAP:   begin step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); end
      default: ;
    endcase
    check("R2", {fA, lA, rA}, expAct(s));
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // Exhaustive: every state against every sensor pair.
    for (int s = 0; s < 5; s++) begin
      for (int v = 0; v < 4; v++) begin
        gotoState(mstate_t'(s));
        step(v[1], v[0]);
        check("R2", {1'b0, lA & rA}, 2'b00);
      end
    end
    // Reset taking effect from every state.
    for (int s = 0; s < 5; s++) begin
      gotoState(mstate_t'(s));
      doReset();
    end
    // Long random runs through both builds together.
    doReset();
    for (int i = 0; i < RAND_STEPS; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if (i % 997 == 996) doReset();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule